// File: doc/BRIEF.md
# Shader Thread Dispatch Arbiter

The block sits in front of one SIMD array. It chooses which waiting shader thread the array runs next. Vertex, geometry and pixel threads each arrive on their own request queue. Every queued thread carries:

- a thread identifier,
- a need level,
- a resource class, which must be marked available before the thread may run.

A thread is always handled as one whole unit of 64 data elements and is never split.

The array has two issue slots, so two threads can be in flight at once. When a slot is free, the highest-priority eligible thread is issued into it. A thread waiting on slow data is marked asleep. It stays in its queue but cannot be chosen until a wake event naming it arrives.

When both slots are occupied and a waiting thread has a strictly higher need level than a running one, the block preempts the running thread. It signals, for one cycle, that the running thread's context must be saved, and issues the newcomer into the freed slot. Fetch requests are arbitrated elsewhere. This block handles only ALU thread issue.

Top module: `disp_arbiter`

## Requirements
- R1: Each shader type has its own queue of 8 entries. Type codes are vertex = 0, geometry = 1 and pixel = 2, and bit t of `enq_valid_i`/`enq_ready_o` belongs to type t. `enq_ready_o[t]` is low exactly when queue t is full, and an enqueue offered to a full queue is dropped.
- R2: An entry is eligible only when it is valid, awake, and bit `res` of `res_avail_i` is set, where `res` is the entry's resource class. Only eligible entries are issued, and a free slot stays idle when nothing is eligible.
- R3: Among eligible entries, a higher need level always wins.
- R4: At equal need, the greater age wins. Age starts at 0 on enqueue, rises by one each cycle the entry is eligible but not chosen, and saturates at 63.
- R5: At equal need and age, pixel beats vertex and vertex beats geometry. The lowest queue index breaks any remaining tie.
- R6: `sleep_valid_i` puts queued entries with a matching thread ID to sleep, and `wake_valid_i` wakes them. When both name the same thread in one cycle, the wake takes effect.
- R7: There are two slots, and at most one thread is issued per cycle, into the lowest-numbered free slot. `issue_valid_o` pulses for one cycle, two clock edges after the event that made the issue possible, with the slot, thread ID, type and need. A `done_i[s]` pulse frees slot s.
- R8: With both slots busy, a candidate preempts only if its need is strictly greater than the lowest running need. The victim is the slot with the lowest need, with ties going to slot 0. `preempt_valid_o` pulses for one cycle with the victim's slot and thread ID, and in the same cycle the candidate is issued into that slot.
- R9: After reset, all queues are empty, all slots are free and no issue or preempt pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 3 | Enqueue strobe, one bit per shader type |
| enq_tid_i | input | 3*TID_W | Thread ID per type, type t at bits [t*TID_W +: TID_W] |
| enq_need_i | input | 3*NEED_W | Need level per type |
| enq_res_i | input | 3*RES_W | Resource class per type |
| enq_ready_o | output | 3 | Queue has a free entry |
| sleep_valid_i | input | 1 | Put the named thread to sleep |
| sleep_tid_i | input | TID_W | Thread to sleep |
| wake_valid_i | input | 1 | Data arrived for the named thread |
| wake_tid_i | input | TID_W | Thread to wake |
| res_avail_i | input | 2**RES_W | Availability per resource class |
| done_i | input | SLOTS | Slot s has finished its thread |
| issue_valid_o | output | 1 | Issue pulse |
| issue_slot_o | output | SLOT_W | Target slot |
| issue_tid_o | output | TID_W | Issued thread ID |
| issue_type_o | output | 2 | Issued shader type |
| issue_need_o | output | NEED_W | Issued need level |
| preempt_valid_o | output | 1 | Save-context request pulse |
| preempt_slot_o | output | SLOT_W | Victim slot |
| preempt_tid_o | output | TID_W | Victim thread ID |

## Verification
The embedded assertions check the following on every cycle:

- each popped entry really was eligible,
- a full queue leaves its contents unchanged,
- age holds once it has saturated,
- a wake always clears sleep,
- at most one queue pops per cycle,
- an issued slot is marked busy,
- a preempt is paired with an issue into the same slot, and only ever happens with both slots busy.

The order of priority needs the directed scenarios, because it shows only in which thread comes out first:

- need over age,
- age over type,
- pixel over vertex over geometry,
- index order in a drained full queue.

The same holds for the strict-greater preemption boundary, sleep hiding a thread from a free slot, a blocked resource class, and a dropped enqueue into a full queue.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int NUM_TY = 3;

  typedef enum logic [1:0] {
    TY_VERT = 2'd0,
    TY_GEOM = 2'd1,
    TY_PIX  = 2'd2
  } shader_ty_e;

  // tie-break rank: pixel > vertex > geometry
  function automatic logic [1:0] ty_rank(input logic [1:0] ty);
    case (ty)
      2'd2:    return 2'd2;
      2'd0:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/disp_pick.sv
module disp_pick #(
  parameter int N     = 8,
  parameter int KEY_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       vld_i,
  input  logic [N*KEY_W-1:0] key_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [KEY_W-1:0] best;

  // strict compare keeps the lowest index on equal keys
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_i[i] && (!any_o || key_i[i*KEY_W +: KEY_W] > best)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = key_i[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/disp_queue.sv
module disp_queue #(
  parameter int DEPTH  = 8,
  parameter int TID_W  = 8,
  parameter int NEED_W = 2,
  parameter int RES_W  = 2,
  parameter int AGE_W  = 6,
  localparam int QIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NRES   = 1 << RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [TID_W-1:0]  enq_tid_i,
  input  logic [NEED_W-1:0] enq_need_i,
  input  logic [RES_W-1:0]  enq_res_i,
  output logic              enq_ready_o,
  input  logic              sleep_valid_i,
  input  logic [TID_W-1:0]  sleep_tid_i,
  input  logic              wake_valid_i,
  input  logic [TID_W-1:0]  wake_tid_i,
  input  logic [NRES-1:0]   res_avail_i,
  input  logic              pop_i,
  output logic              best_valid_o,
  output logic [NEED_W-1:0] best_need_o,
  output logic [AGE_W-1:0]  best_age_o,
  output logic [QIDX_W-1:0] best_idx_o,
  output logic [TID_W-1:0]  best_tid_o
);
  localparam int LKEY_W = NEED_W + AGE_W + QIDX_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [DEPTH-1:0]  ent_vld;
  logic [DEPTH-1:0]  ent_slp;
  logic [TID_W-1:0]  ent_tid  [DEPTH];
  logic [NEED_W-1:0] ent_need [DEPTH];
  logic [RES_W-1:0]  ent_res  [DEPTH];
  logic [AGE_W-1:0]  ent_age  [DEPTH];

  logic [DEPTH-1:0]        elig;
  logic [DEPTH*LKEY_W-1:0] lkey;
  logic                    free_any;
  logic [QIDX_W-1:0]       free_idx;
  logic                    enq_fire;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = ent_vld[i] && !ent_slp[i] && res_avail_i[ent_res[i]];
      lkey[i*LKEY_W +: LKEY_W] = {ent_need[i], ent_age[i], QIDX_W'(DEPTH-1-i)};
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        free_any = 1'b1;
        free_idx = QIDX_W'(i);
      end
    end
  end

  assign enq_ready_o = free_any;
  assign enq_fire    = enq_valid_i && free_any;

  disp_pick #(.N(DEPTH), .KEY_W(LKEY_W)) u_pick (
    .vld_i (elig),
    .key_i (lkey),
    .any_o (best_valid_o),
    .idx_o (best_idx_o)
  );

  assign best_need_o = ent_need[best_idx_o];
  assign best_age_o  = ent_age[best_idx_o];
  assign best_tid_o  = ent_tid[best_idx_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld <= '0;
      ent_slp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_tid[i]  <= '0;
        ent_need[i] <= '0;
        ent_res[i]  <= '0;
        ent_age[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop_i && best_idx_o == QIDX_W'(i)) ent_vld[i] <= 1'b0;
        else if (elig[i] && ent_age[i] != AGE_MAX) ent_age[i] <= ent_age[i] + AGE_W'(1);
        // wake wins over a same-cycle sleep
        if (wake_valid_i && ent_tid[i] == wake_tid_i) ent_slp[i] <= 1'b0;
        else if (sleep_valid_i && ent_vld[i] && ent_tid[i] == sleep_tid_i) ent_slp[i] <= 1'b1;
        if (enq_fire && free_idx == QIDX_W'(i)) begin
          ent_vld[i]  <= 1'b1;
          ent_slp[i]  <= 1'b0;
          ent_tid[i]  <= enq_tid_i;
          ent_need[i] <= enq_need_i;
          ent_res[i]  <= enq_res_i;
          ent_age[i]  <= '0;
        end
      end
    end
  end

  AST_POP_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> (ent_vld[best_idx_o] && !ent_slp[best_idx_o] && res_avail_i[ent_res[best_idx_o]])); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) (enq_valid_i && !enq_ready_o && !pop_i) |=> $stable(ent_vld)); // R1

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent_chk
    AST_AGE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni) (ent_vld[g] && ent_age[g] == AGE_MAX && !(pop_i && best_idx_o == QIDX_W'(g))) |=> ent_age[g] == AGE_MAX); // R4
    AST_WAKE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) (ent_vld[g] && wake_valid_i && ent_tid[g] == wake_tid_i && !(pop_i && best_idx_o == QIDX_W'(g))) |=> !ent_slp[g]); // R6
  end
endmodule

// File: rtl/disp_slots.sv
module disp_slots #(
  parameter int SLOTS  = 2,
  parameter int TID_W  = 8,
  parameter int NEED_W = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [NEED_W-1:0] cand_need_i,
  input  logic [TID_W-1:0]  cand_tid_i,
  input  logic [1:0]        cand_type_i,
  input  logic [SLOTS-1:0]  done_i,
  output logic              grant_o,
  output logic              issue_valid_o,
  output logic [SLOT_W-1:0] issue_slot_o,
  output logic [TID_W-1:0]  issue_tid_o,
  output logic [1:0]        issue_type_o,
  output logic [NEED_W-1:0] issue_need_o,
  output logic              preempt_valid_o,
  output logic [SLOT_W-1:0] preempt_slot_o,
  output logic [TID_W-1:0]  preempt_tid_o
);
  logic [SLOTS-1:0]  busy;
  logic [NEED_W-1:0] s_need [SLOTS];
  logic [TID_W-1:0]  s_tid  [SLOTS];

  logic              free_any;
  logic [SLOT_W-1:0] free_idx;
  logic [SLOT_W-1:0] victim;
  logic              preempt_ok;
  logic [SLOT_W-1:0] tgt;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int s = SLOTS-1; s >= 0; s--) begin
      if (!busy[s]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(s);
      end
    end
    // lowest running need, lowest slot on ties
    victim = '0;
    for (int s = 1; s < SLOTS; s++) begin
      if (s_need[s] < s_need[victim]) victim = SLOT_W'(s);
    end
  end

  assign preempt_ok = cand_valid_i && !free_any && (cand_need_i > s_need[victim]);
  assign grant_o    = cand_valid_i && (free_any || preempt_ok);
  assign tgt        = free_any ? free_idx : victim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy            <= '0;
      issue_valid_o   <= 1'b0;
      issue_slot_o    <= '0;
      issue_tid_o     <= '0;
      issue_type_o    <= '0;
      issue_need_o    <= '0;
      preempt_valid_o <= 1'b0;
      preempt_slot_o  <= '0;
      preempt_tid_o   <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        s_need[s] <= '0;
        s_tid[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (done_i[s]) busy[s] <= 1'b0;
      end
      if (grant_o) begin
        busy[tgt]   <= 1'b1;
        s_need[tgt] <= cand_need_i;
        s_tid[tgt]  <= cand_tid_i;
      end
      issue_valid_o   <= grant_o;
      issue_slot_o    <= tgt;
      issue_tid_o     <= cand_tid_i;
      issue_type_o    <= cand_type_i;
      issue_need_o    <= cand_need_i;
      preempt_valid_o <= preempt_ok;
      preempt_slot_o  <= victim;
      preempt_tid_o   <= s_tid[victim];
    end
  end

  AST_PREEMPT_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni) preempt_valid_o |-> (issue_valid_o && issue_slot_o == preempt_slot_o)); // R8
  AST_PREEMPT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni) preempt_valid_o |-> $past(&busy)); // R8
  AST_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) issue_valid_o |-> busy[issue_slot_o]); // R7
endmodule

// File: rtl/disp_arbiter.sv
module disp_arbiter #(
  parameter int DEPTH  = 8,
  parameter int TID_W  = 8,
  parameter int NEED_W = 2,
  parameter int RES_W  = 2,
  parameter int AGE_W  = 6,
  parameter int SLOTS  = 2,
  localparam int NTY    = disp_pkg::NUM_TY,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NRES   = 1 << RES_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NTY-1:0]        enq_valid_i,
  input  logic [NTY*TID_W-1:0]  enq_tid_i,
  input  logic [NTY*NEED_W-1:0] enq_need_i,
  input  logic [NTY*RES_W-1:0]  enq_res_i,
  output logic [NTY-1:0]        enq_ready_o,
  input  logic                  sleep_valid_i,
  input  logic [TID_W-1:0]      sleep_tid_i,
  input  logic                  wake_valid_i,
  input  logic [TID_W-1:0]      wake_tid_i,
  input  logic [NRES-1:0]       res_avail_i,
  input  logic [SLOTS-1:0]      done_i,
  output logic                  issue_valid_o,
  output logic [SLOT_W-1:0]     issue_slot_o,
  output logic [TID_W-1:0]      issue_tid_o,
  output logic [1:0]            issue_type_o,
  output logic [NEED_W-1:0]     issue_need_o,
  output logic                  preempt_valid_o,
  output logic [SLOT_W-1:0]     preempt_slot_o,
  output logic [TID_W-1:0]      preempt_tid_o
);
  localparam int QIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int GKEY_W = NEED_W + AGE_W + 2 + QIDX_W;
  localparam int TY_W   = 2;

  logic [NTY-1:0]        q_valid;
  logic [NTY-1:0]        q_pop;
  logic [NEED_W-1:0]     q_need [NTY];
  logic [AGE_W-1:0]      q_age  [NTY];
  logic [QIDX_W-1:0]     q_idx  [NTY];
  logic [TID_W-1:0]      q_tid  [NTY];
  logic [NTY*GKEY_W-1:0] gkey;

  logic              win_any;
  logic [TY_W-1:0]   win_ty;
  logic              grant;

  for (genvar t = 0; t < NTY; t++) begin : g_q
    disp_queue #(
      .DEPTH(DEPTH), .TID_W(TID_W), .NEED_W(NEED_W), .RES_W(RES_W), .AGE_W(AGE_W)
    ) u_queue (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .enq_valid_i   (enq_valid_i[t]),
      .enq_tid_i     (enq_tid_i[t*TID_W +: TID_W]),
      .enq_need_i    (enq_need_i[t*NEED_W +: NEED_W]),
      .enq_res_i     (enq_res_i[t*RES_W +: RES_W]),
      .enq_ready_o   (enq_ready_o[t]),
      .sleep_valid_i (sleep_valid_i),
      .sleep_tid_i   (sleep_tid_i),
      .wake_valid_i  (wake_valid_i),
      .wake_tid_i    (wake_tid_i),
      .res_avail_i   (res_avail_i),
      .pop_i         (q_pop[t]),
      .best_valid_o  (q_valid[t]),
      .best_need_o   (q_need[t]),
      .best_age_o    (q_age[t]),
      .best_idx_o    (q_idx[t]),
      .best_tid_o    (q_tid[t])
    );

    assign gkey[t*GKEY_W +: GKEY_W] =
      {q_need[t], q_age[t], disp_pkg::ty_rank(TY_W'(t)), QIDX_W'(DEPTH-1) - q_idx[t]};
    assign q_pop[t] = grant && win_ty == TY_W'(t);
  end

  disp_pick #(.N(NTY), .KEY_W(GKEY_W)) u_gpick (
    .vld_i (q_valid),
    .key_i (gkey),
    .any_o (win_any),
    .idx_o (win_ty)
  );

  disp_slots #(.SLOTS(SLOTS), .TID_W(TID_W), .NEED_W(NEED_W)) u_slots (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cand_valid_i    (win_any),
    .cand_need_i     (q_need[win_ty]),
    .cand_tid_i      (q_tid[win_ty]),
    .cand_type_i     (win_ty),
    .done_i          (done_i),
    .grant_o         (grant),
    .issue_valid_o   (issue_valid_o),
    .issue_slot_o    (issue_slot_o),
    .issue_tid_o     (issue_tid_o),
    .issue_type_o    (issue_type_o),
    .issue_need_o    (issue_need_o),
    .preempt_valid_o (preempt_valid_o),
    .preempt_slot_o  (preempt_slot_o),
    .preempt_tid_o   (preempt_tid_o)
  );

  AST_ONE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(q_pop)); // R7
endmodule

// File: tb/disp_arbiter_tb.sv
module disp_arbiter_tb;
  localparam int TID_W = 8, NEED_W = 2, RES_W = 2, SLOTS = 2;
  localparam logic [1:0] VT = 2'd0, GT = 2'd1, PT = 2'd2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]        enq_valid_i = '0;
  logic [3*TID_W-1:0]  enq_tid_i = '0;
  logic [3*NEED_W-1:0] enq_need_i = '0;
  logic [3*RES_W-1:0]  enq_res_i = '0;
  logic [2:0]        enq_ready_o;
  logic              sleep_valid_i = 1'b0;
  logic [TID_W-1:0]  sleep_tid_i = '0;
  logic              wake_valid_i = 1'b0;
  logic [TID_W-1:0]  wake_tid_i = '0;
  logic [3:0]        res_avail_i = 4'hF;
  logic [SLOTS-1:0]  done_i = '0;
  logic              issue_valid_o;
  logic [0:0]        issue_slot_o;
  logic [TID_W-1:0]  issue_tid_o;
  logic [1:0]        issue_type_o;
  logic [NEED_W-1:0] issue_need_o;
  logic              preempt_valid_o;
  logic [0:0]        preempt_slot_o;
  logic [TID_W-1:0]  preempt_tid_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  disp_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_tid_i(enq_tid_i), .enq_need_i(enq_need_i),
    .enq_res_i(enq_res_i), .enq_ready_o(enq_ready_o),
    .sleep_valid_i(sleep_valid_i), .sleep_tid_i(sleep_tid_i),
    .wake_valid_i(wake_valid_i), .wake_tid_i(wake_tid_i),
    .res_avail_i(res_avail_i), .done_i(done_i),
    .issue_valid_o(issue_valid_o), .issue_slot_o(issue_slot_o), .issue_tid_o(issue_tid_o),
    .issue_type_o(issue_type_o), .issue_need_o(issue_need_o),
    .preempt_valid_o(preempt_valid_o), .preempt_slot_o(preempt_slot_o),
    .preempt_tid_o(preempt_tid_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_issue(input string tag, input int slot, input int tid, input int ty);
    check({tag, " issue_valid"}, int'(issue_valid_o), 1);
    check({tag, " slot"}, int'(issue_slot_o), slot);
    check({tag, " tid"}, int'(issue_tid_o), tid);
    check({tag, " type"}, int'(issue_type_o), ty);
  endtask

  task automatic expect_none(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      check({tag, " no issue"}, int'(issue_valid_o), 0);
      tick(1);
    end
  endtask

  task automatic set_enq(input logic [1:0] ty, input int tid, input int need, input int res);
    enq_valid_i[ty] = 1'b1;
    enq_tid_i[ty*TID_W +: TID_W] = TID_W'(tid);
    enq_need_i[ty*NEED_W +: NEED_W] = NEED_W'(need);
    enq_res_i[ty*RES_W +: RES_W] = RES_W'(res);
  endtask

  task automatic enq(input logic [1:0] ty, input int tid, input int need, input int res);
    set_enq(ty, tid, need, res);
    tick(1);
    enq_valid_i = '0;
  endtask

  task automatic release_slot(input int s);
    done_i[s] = 1'b1;
    tick(1);
    done_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    enq_valid_i = '0; sleep_valid_i = 1'b0; wake_valid_i = 1'b0;
    done_i = '0; res_avail_i = 4'hF;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  // occupy both slots: tid 0xF0 -> slot 0, tid 0xF1 -> slot 1
  task automatic fill_slots(input int need);
    enq(VT, 8'hF0, need, 0);
    enq(VT, 8'hF1, need, 0);
    tick(3);
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 issue_valid", int'(issue_valid_o), 0);
    check("R9 preempt_valid", int'(preempt_valid_o), 0);
    check("R9 enq_ready", int'(enq_ready_o), 7);
    enq(PT, 5, 1, 0);
    tick(1);
    expect_issue("R7 first issue", 0, 5, PT);
    tick(1);
    check("R7 issue pulse one cycle", int'(issue_valid_o), 0);
  endtask

  task automatic t_type_tie();
    do_reset();
    fill_slots(3);
    set_enq(VT, 10, 1, 0);
    set_enq(GT, 11, 1, 0);
    set_enq(PT, 12, 1, 0);
    tick(1);
    enq_valid_i = '0;
    release_slot(0); tick(1);
    expect_issue("R5 pixel first", 0, 12, PT);
    release_slot(0); tick(1);
    expect_issue("R5 vertex second", 0, 10, VT);
    release_slot(0); tick(1);
    expect_issue("R5 geometry last", 0, 11, GT);
  endtask

  task automatic t_need();
    do_reset();
    fill_slots(3);
    enq(PT, 20, 1, 0);
    tick(5);
    enq(GT, 21, 2, 0);
    release_slot(1); tick(1);
    expect_issue("R3 need wins", 1, 21, GT);
    release_slot(1); tick(1);
    expect_issue("R3 lower need after", 1, 20, PT);
  endtask

  task automatic t_age();
    do_reset();
    fill_slots(3);
    enq(GT, 30, 1, 0);
    tick(3);
    enq(PT, 31, 1, 0);
    release_slot(0); tick(1);
    expect_issue("R4 older geometry wins", 0, 30, GT);
    release_slot(0); tick(1);
    expect_issue("R4 younger pixel next", 0, 31, PT);
  endtask

  task automatic t_sleep();
    do_reset();
    fill_slots(3);
    enq(PT, 40, 1, 0);
    sleep_valid_i = 1'b1; sleep_tid_i = 40;
    tick(1);
    sleep_valid_i = 1'b0;
    release_slot(0);
    expect_none("R6 asleep not issued", 4);
    enq(VT, 41, 1, 0); tick(1);
    expect_issue("R6 awake thread issued", 0, 41, VT);
    wake_valid_i = 1'b1; wake_tid_i = 40;
    tick(1);
    wake_valid_i = 1'b0;
    release_slot(0); tick(1);
    expect_issue("R6 woken thread issued", 0, 40, PT);
    enq(PT, 42, 1, 0);
    sleep_valid_i = 1'b1; sleep_tid_i = 42;
    wake_valid_i = 1'b1; wake_tid_i = 42;
    tick(1);
    sleep_valid_i = 1'b0; wake_valid_i = 1'b0;
    release_slot(0); tick(1);
    expect_issue("R6 wake beats sleep", 0, 42, PT);
  endtask

  task automatic t_res();
    do_reset();
    fill_slots(3);
    res_avail_i = 4'b1011;
    enq(PT, 50, 1, 2);
    release_slot(0);
    expect_none("R2 blocked resource", 3);
    enq(VT, 51, 1, 0); tick(1);
    expect_issue("R2 available resource issued", 0, 51, VT);
    res_avail_i = 4'hF;
    release_slot(0); tick(1);
    expect_issue("R2 unblocked issued", 0, 50, PT);
  endtask

  task automatic t_preempt();
    do_reset();
    fill_slots(1);
    enq(PT, 62, 1, 0);
    for (int i = 0; i < 3; i++) begin
      check("R8 equal need no preempt", int'(preempt_valid_o), 0);
      check("R8 equal need no issue", int'(issue_valid_o), 0);
      tick(1);
    end
    enq(VT, 63, 2, 0);
    tick(1);
    check("R8 preempt pulse", int'(preempt_valid_o), 1);
    check("R8 victim slot", int'(preempt_slot_o), 0);
    check("R8 victim tid", int'(preempt_tid_o), 8'hF0);
    expect_issue("R8 preemptor issued", 0, 63, VT);
    tick(1);
    check("R8 preempt one cycle", int'(preempt_valid_o), 0);
    check("R8 no further issue", int'(issue_valid_o), 0);
  endtask

  task automatic t_full();
    do_reset();
    fill_slots(3);
    for (int i = 0; i < 8; i++) enq(VT, 8'h80 + i, 0, 0);
    check("R1 vertex queue full", int'(enq_ready_o), 6);
    enq(VT, 8'h99, 0, 0);
    tick(2);
    for (int i = 0; i < 8; i++) begin
      release_slot(0); tick(1);
      expect_issue("R1 drain order", 0, 8'h80 + i, VT);
      if (i == 0) check("R1 ready after pop", int'(enq_ready_o[0]), 1);
    end
    release_slot(0);
    expect_none("R1 dropped entry absent", 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_type_tie();
    t_need();
    t_age();
    t_sleep();
    t_res();
    t_preempt();
    t_full();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule